// File: doc/BRIEF.md
# Two-Phase Host Register Write Decoder

This block turns a narrow parallel host bus into register writes for three internal units: two tone voices and a mixer. Address and data travel over the same six pins, so each write is split in two. When the selector input is low, the pins carry an address and the block latches it. When the selector is high, the pins carry a value. That value goes out on the data bus, and a strobe fires toward the register that the latched address selects.

The latched address has two parts. Its upper field picks a unit and its lowest bit picks one of the two registers inside that unit. The address stays latched until the next address phase. A host can therefore stream several values into one register without sending the address again. Both inputs are sampled on the system clock. Each strobe is combinational from the current selector, the current bus and the latched address, so a consumer captures the data on the same clock edge at which the data phase is sampled.

Top module: `regwr_host_port`

## Requirements
- R1: After a synchronous active-low reset the latched address is 0, so a data phase with no prior address phase strobes voice 0 register 0 (strobe bit 0).
- R2: A cycle with the selector low loads bus bits [2:0] into the address latch at the clock edge and raises no strobe.
- R3: In a cycle with the selector high, at most one strobe bit is high, at index 2*unit+register. The unit is address bits [2:1] (00 voice 0, 01 voice 1, 10 mixer) and the register is address bit 0.
- R4: While a strobe is high, the data output equals the bus value of that same cycle.
- R5: Data phases leave the latched address unchanged, so consecutive data phases strobe the same register.
- R6: A data phase while address bits [2:1] are 11 raises no strobe.
- R7: A strobe is high only in a cycle whose selector is high, so each sampled data phase gives exactly one cycle of strobe.
- R8: Bus bits [5:3] of an address phase have no effect on which register is selected.
- R9: While reset is low, no strobe is raised regardless of the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | 0 = address phase, 1 = data phase |
| host_bus | input | 6 | Shared address/data pins |
| wr_stb | output | 6 | One-hot write strobes, index 2*unit+register |
| wr_data | output | 6 | Value to be written |

## Verification
The only internal state is the latched address. If it is wrong, the very next data phase shows it at the ports: the strobe lands on the wrong bit, or no strobe appears at all. An error made at one clock edge is therefore visible one cycle later, at the first data phase that follows. For that reason the bench places a data phase after every address phase, and it repeats data phases to show that the address holds. It also covers the unmapped unit code, the ignored upper bits, and reset while a data phase is active.

// File: rtl/regwr_pkg.sv
// Package: shared widths and the decoded-address type for the host write port.
// Assumes: a power-of-two register count per unit.
package regwr_pkg;
    localparam int BUS_W_DEF    = 6;
    localparam int UNITS_DEF    = 3;
    localparam int REGS_DEF     = 2;
    localparam int REG_SEL_W    = $clog2(REGS_DEF);
    localparam int UNIT_SEL_W   = 2;
    localparam int ADDR_W       = REG_SEL_W + UNIT_SEL_W;

    // Decoded view of the latched address.
    typedef struct packed {
        logic [UNIT_SEL_W-1:0] unit;
        logic [REG_SEL_W-1:0]  regi;
    } addr_fields_t;
endpackage

// File: rtl/regwr_addr_latch.sv
// Module: address latch. It captures the low ADDR_W bus bits during an address
// phase and holds them through data phases.
// Assumes: host_sel and host_bus are already synchronous to clk.
module regwr_addr_latch
    import regwr_pkg::*;
#(
    parameter int BUS_W = BUS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic [BUS_W-1:0] host_bus,
    output addr_fields_t     addr_q
);
    // Load the address on an address phase and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (!host_sel)
            addr_q <= addr_fields_t'(host_bus[ADDR_W-1:0]);
    end
endmodule

// File: rtl/regwr_decode.sv
// Module: strobe decoder. It turns the latched address plus a write enable into
// one-hot strobes. Unit codes of UNITS and above decode to no strobe.
// Assumes: UNITS <= 2**UNIT_SEL_W and REGS == 2**REG_SEL_W.
module regwr_decode
    import regwr_pkg::*;
#(
    parameter int UNITS = UNITS_DEF,
    parameter int REGS  = REGS_DEF,
    localparam int STB_W = UNITS * REGS
) (
    input  logic             wr_en,
    input  addr_fields_t     addr,
    output logic [STB_W-1:0] stb
);
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        for (genvar r = 0; r < REGS; r++) begin : g_reg
            // Match one unit/register pair.
            always_comb
                stb[u*REGS + r] = wr_en
                                  && (addr.unit == UNIT_SEL_W'(u))
                                  && (addr.regi == REG_SEL_W'(r));
        end
    end
endmodule

// File: rtl/regwr_host_port.sv
// Module: top of the two-phase host write port. It latches the address during
// address phases and, during data phases, drives the data and one strobe.
// Assumes: host inputs are synchronous; consumers capture wr_data on the clock
// edge at which the matching strobe is high.
module regwr_host_port
    import regwr_pkg::*;
#(
    parameter int BUS_W = BUS_W_DEF,
    parameter int UNITS = UNITS_DEF,
    parameter int REGS  = REGS_DEF,
    localparam int STB_W = UNITS * REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic [BUS_W-1:0] host_bus,
    output logic [STB_W-1:0] wr_stb,
    output logic [BUS_W-1:0] wr_data
);
    addr_fields_t addr_q;
    logic         wr_en;

    regwr_addr_latch #(.BUS_W(BUS_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_sel (host_sel),
        .host_bus (host_bus),
        .addr_q   (addr_q)
    );

    // A write is permitted only in a data phase outside reset.
    always_comb wr_en = host_sel && rst_n;

    regwr_decode #(.UNITS(UNITS), .REGS(REGS)) u_dec (
        .wr_en (wr_en),
        .addr  (addr_q),
        .stb   (wr_stb)
    );

    // The data is presented straight from the shared pins.
    always_comb wr_data = host_bus;
endmodule

// File: rtl/regwr_host_port_chk.sv
// Module: assertion checker for regwr_host_port, attached by bind.
module regwr_host_port_chk
    import regwr_pkg::*;
#(
    parameter int BUS_W = 6,
    parameter int STB_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_sel,
    input logic [BUS_W-1:0] host_bus,
    input logic [STB_W-1:0] wr_stb,
    input logic [BUS_W-1:0] wr_data,
    input addr_fields_t     addr_q
);
    // R1: reset clears the latched address.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> addr_q == '0);
    // R2: an address phase loads the low bus bits.
    p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |=> addr_q == addr_fields_t'($past(host_bus[ADDR_W-1:0])));
    // R3: at most one strobe bit is high.
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_stb));
    // R4: data accompanies the strobe.
    p_data_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> wr_data == host_bus);
    // R5: data phases hold the address.
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel |=> $stable(addr_q));
    // R6: the unmapped unit code gives no strobe.
    p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q.unit == 2'b11) |-> wr_stb == '0);
    // R7: a strobe needs the data selector.
    p_stb_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |-> host_sel);
    // R9: no strobe during reset (immediate check at the edge).
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r9: assert (wr_stb == '0);
        end
    end
endmodule

bind regwr_host_port regwr_host_port_chk #(.BUS_W(BUS_W), .STB_W(STB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_sel (host_sel),
    .host_bus (host_bus),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .addr_q   (addr_q)
);

// File: tb/test_regwr_host_port.sv
// Bench for regwr_host_port: a vector table walk, then directed reset cases.
module test_regwr_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic [5:0] host_bus = '0;
    logic [5:0] wr_stb;
    logic [5:0] wr_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    regwr_host_port i_regwr_host_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel),
        .host_bus(host_bus), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    // Entry: {sel, bus[5:0], expected strobe[5:0]}.
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 6'h2A, 6'b000001},  // R1 reset address selects voice 0 reg 0
        {1'b0, 6'h01, 6'b000000},  // R2 address phase, no strobe
        {1'b1, 6'h15, 6'b000010},  // R3 voice 0 reg 1
        {1'b0, 6'h02, 6'b000000},  // R2
        {1'b1, 6'h3F, 6'b000100},  // R3 voice 1 reg 0
        {1'b0, 6'h03, 6'b000000},  // R2
        {1'b1, 6'h00, 6'b001000},  // R3 voice 1 reg 1
        {1'b1, 6'h11, 6'b001000},  // R5 address held
        {1'b0, 6'h04, 6'b000000},  // R2
        {1'b1, 6'h07, 6'b010000},  // R3 mixer reg 0
        {1'b0, 6'h05, 6'b000000},  // R2
        {1'b1, 6'h3E, 6'b100000},  // R3 mixer reg 1
        {1'b0, 6'h06, 6'b000000},  // R2 unmapped unit
        {1'b1, 6'h12, 6'b000000},  // R6
        {1'b0, 6'h07, 6'b000000},  // R2 unmapped unit
        {1'b1, 6'h12, 6'b000000},  // R6
        {1'b0, 6'h3B, 6'b000000},  // R8 upper bits set, low 011
        {1'b1, 6'h09, 6'b001000}   // R8 decodes as voice 1 reg 1
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive after a falling edge, then compare 1 ns later, before the rising edge.
    task automatic step(input logic sel, input logic [5:0] bus);
        @(negedge clk);
        host_sel = sel;
        host_bus = bus;
        #1;
    endtask

    initial begin : watchdog
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R9: quiet during reset, even with a data phase present.
        step(1'b1, 6'h00);
        check("R9", wr_stb, 6'b000000);
        step(1'b1, 6'h00);
        check("R9", wr_stb, 6'b000000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12], VEC[i][11:6]);
            check("R3", wr_stb, VEC[i][5:0]);
            if (VEC[i][12]) check("R4", wr_data, VEC[i][11:6]);
        end
        // R7: a strobe lasts one cycle, then drops in the next address phase.
        step(1'b0, 6'h02);
        check("R7", wr_stb, 6'b000000);
        step(1'b1, 6'h21);
        check("R7", wr_stb, 6'b000100);
        // R9 then R1: reset in mid-run discards the address.
        step(1'b0, 6'h05);
        @(negedge clk);
        rst_n = 1'b0;
        host_sel = 1'b1;
        #1;
        check("R9", wr_stb, 6'b000000);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", wr_stb, 6'b000001);
        check("R4", wr_data, 6'h05);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule